// File: doc/BRIEF.md
# Banked Status Register Transfer Unit

This block keeps the processor's current status word and one saved status word for each privileged mode bank, and carries out the four transfers between those words and the register file. The four transfers are: copy the current word out, load the current word, copy the active bank's saved word out, and load that saved word. Each load is either a full replacement or a flags-only update, which changes just the four condition flags. Privilege filters every load. An unprivileged full load of the current word is cut down to a flags-only load. Saved words cannot be reached at all without privilege.

A separate restore request copies the active bank's saved word into the current word in a single step. This serves exception return, where a data-processing result goes to the program counter with flag setting enabled. Instruction decode and register-file access stay outside the block. The caller presents an operation, a source value, the privilege level and the bank index, and receives registered read data, the live current word and a one-cycle mode-change strobe.

Top module: `psr_xfer_unit`

## Requirements
- R1: Synchronous active-low reset sets `cpsr_q` to 0x000000D3 (supervisor mode 0x13 in bits 4:0, both interrupt masks at bits 7 and 6 set). It clears `rd_data`, `rd_valid`, `mode_chg` and every saved word.
- R2: An accepted operation with `op_sel`=0 (read current) loads `rd_data` with the pre-edge `cpsr_q` and raises `rd_valid` for exactly the following cycle.
- R3: An accepted operation with `op_sel`=1, `full_sel`=1 and `priv_mode`=1 replaces `cpsr_q` with `src_value` at the next edge and pulses `mode_chg` for one cycle.
- R4: A flags-only load (`full_sel`=0) copies `src_value[31:28]` into bits 31:28 of the target word and keeps bits 27:0. It never pulses `mode_chg`.
- R5: With `priv_mode`=0, a full load of the current word (`op_sel`=1) acts as a flags-only load and does not pulse `mode_chg`.
- R6: An accepted operation with `op_sel`=2 (read saved), `priv_mode`=1 and a bank index below NUM_BANKS returns that bank's saved word on `rd_data` with `rd_valid` high on the next cycle.
- R7: An accepted operation with `op_sel`=3 (write saved) under privilege updates the indexed saved word, fully or flags-only as `full_sel` selects. It leaves `cpsr_q` unchanged.
- R8: A saved-word operation (`op_sel` 2 or 3) with `priv_mode`=0, or with `bank_idx` ≥ NUM_BANKS, has no effect. No saved word changes, `rd_valid` stays low and `rd_data` holds.
- R9: `restore_req` with `priv_mode`=1 and a valid bank copies that bank's saved word into `cpsr_q` and pulses `mode_chg`. Any `restore_req` blocks an operation presented in the same cycle. A restore without privilege changes nothing.
- R10: Writing one bank's saved word leaves every other bank's saved word unchanged.
- R11: While `op_valid` and `restore_req` are both low, `cpsr_q` and the saved words stay unchanged, and `rd_valid` and `mode_chg` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 2 | 0 read current, 1 write current, 2 read saved, 3 write saved |
| full_sel | input | 1 | 1 full load, 0 flags-only load |
| src_value | input | 32 | Source word for loads |
| priv_mode | input | 1 | High in a privileged mode |
| bank_idx | input | 3 | Bank of the current mode |
| restore_req | input | 1 | Copy the current bank's saved word into the current word |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | `rd_data` was loaded on the last edge |
| cpsr_q | output | 32 | Current status word |
| mode_chg | output | 1 | One-cycle strobe after a full current-word load or a restore |

## Verification
The checker assumes every input is stable and known at each rising edge. It also assumes `restore_req` has priority, so its properties about operations exclude cycles with a restore. The stimulus changes inputs only on falling edges and holds `rst_n` low from time zero until several edges have passed. It uses bank indices both inside and outside the populated range, so the out-of-range case counts as legal input and not an assumption breach. Each table row fixes all inputs for one edge, including the unused fields of idle rows, so no property ever samples an unknown value.

// File: rtl/psr_xfer_pkg.sv
// Package: shared operation encoding for the status register transfer unit.
// Assumes: op_sel values are decoded directly from the low opcode bits.
package psr_xfer_pkg;

    typedef enum logic [1:0] {
        OP_RD_CUR = 2'd0,
        OP_WR_CUR = 2'd1,
        OP_RD_SAV = 2'd2,
        OP_WR_SAV = 2'd3
    } psr_op_e;

endpackage

// File: rtl/psr_write_merge.sv
// Module: builds the value a status word takes on a load, either the full
// source or the old word with only its top FLAG_W flag bits replaced.
// Assumes: FLAG_W < DATA_W; purely combinational.
module psr_write_merge #(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 4
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] src_word,
    input  logic              full_load,
    output logic [DATA_W-1:0] new_word
);
    localparam logic [DATA_W-1:0] FLAG_MASK =
        {{FLAG_W{1'b1}}, {(DATA_W-FLAG_W){1'b0}}};

    // Select the full source or a flag-field splice.
    always_comb begin
        if (full_load)
            new_word = src_word;
        else
            new_word = (old_word & ~FLAG_MASK) | (src_word & FLAG_MASK);
    end
endmodule

// File: rtl/psr_saved_bank.sv
// Module: one saved status word per privileged bank, with an indexed write
// port and an indexed combinational read port.
// Assumes: out-of-range indices are filtered by the caller for writes; reads
// of an out-of-range index return zero.
module psr_saved_bank #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] bank_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Hold bank b's saved word; load it when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[b] <= '0;
            else if (wr_en && (idx == BANK_W'(b)))
                bank_q[b] <= wr_data;
        end
    end

    // Return the selected bank's word, zero when none matches.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (idx == BANK_W'(b))
                rd_word = bank_q[b];
        end
    end
endmodule

// File: rtl/psr_current_reg.sv
// Module: the current status word register with a parameterised reset value.
// Assumes: the caller resolves priority between load sources.
module psr_current_reg #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_00D3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] next_word,
    output logic [DATA_W-1:0] word_q
);
    // Hold the current word; take the new value on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= RESET_VAL;
        else if (load)
            word_q <= next_word;
    end
endmodule

// File: rtl/psr_xfer_unit.sv
// Module: top of the banked status register transfer unit. Decodes the
// operation, applies privilege and bank-range filtering, and drives the
// current word, the saved bank and the registered read port.
// Assumes: restore_req outranks op_valid; inputs valid at each rising edge.
module psr_xfer_unit
    import psr_xfer_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                FLAG_W    = 4,
    parameter int                NUM_BANKS = 5,
    parameter int                BANK_W    = 3,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_00D3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic              full_sel,
    input  logic [DATA_W-1:0] src_value,
    input  logic              priv_mode,
    input  logic [BANK_W-1:0] bank_idx,
    input  logic              restore_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] cpsr_q,
    output logic              mode_chg
);
    localparam logic [BANK_W:0] BANK_LIMIT = (BANK_W+1)'(NUM_BANKS);

    psr_op_e           op;
    logic              bank_ok, sav_ok, op_go, restore_go;
    logic              cur_wr, cur_full, sav_wr, rd_load;
    logic [DATA_W-1:0] sav_word, cur_merged, sav_merged, cur_next;

    // Decode the request and its privilege and range qualifiers.
    always_comb begin
        op         = psr_op_e'(op_sel);
        bank_ok    = {1'b0, bank_idx} < BANK_LIMIT;
        sav_ok     = priv_mode && bank_ok;
        op_go      = op_valid && !restore_req;
        restore_go = restore_req && sav_ok;
        cur_wr     = op_go && (op == OP_WR_CUR);
        cur_full   = full_sel && priv_mode;
        sav_wr     = op_go && (op == OP_WR_SAV) && sav_ok;
        rd_load    = op_go && ((op == OP_RD_CUR) || ((op == OP_RD_SAV) && sav_ok));
    end

    psr_write_merge #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_cur_merge (
        .old_word  (cpsr_q),
        .src_word  (src_value),
        .full_load (cur_full),
        .new_word  (cur_merged)
    );

    psr_write_merge #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_sav_merge (
        .old_word  (sav_word),
        .src_word  (src_value),
        .full_load (full_sel),
        .new_word  (sav_merged)
    );

    psr_saved_bank #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sav_wr),
        .idx     (bank_idx),
        .wr_data (sav_merged),
        .rd_word (sav_word)
    );

    // Choose the current word's next value: restore beats a load.
    always_comb begin
        cur_next = restore_go ? sav_word : cur_merged;
    end

    psr_current_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_cur (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (restore_go || cur_wr),
        .next_word (cur_next),
        .word_q    (cpsr_q)
    );

    // Register read results and the mode-change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            mode_chg <= 1'b0;
        end else begin
            rd_valid <= rd_load;
            mode_chg <= restore_go || (cur_wr && cur_full);
            if (rd_load)
                rd_data <= (op == OP_RD_CUR) ? cpsr_q : sav_word;
        end
    end
endmodule

// File: rtl/psr_xfer_checker.sv
// Module: property checker for psr_xfer_unit, bound to every instance.
// Assumes: inputs known at each rising edge once reset has been applied.
module psr_xfer_checker #(
    parameter int DATA_W    = 32,
    parameter int FLAG_W    = 4,
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_sel,
    input logic              full_sel,
    input logic [DATA_W-1:0] src_value,
    input logic              priv_mode,
    input logic [BANK_W-1:0] bank_idx,
    input logic              restore_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] cpsr_q,
    input logic              mode_chg
);
    localparam logic [DATA_W-1:0] FMASK =
        {{FLAG_W{1'b1}}, {(DATA_W-FLAG_W){1'b0}}};
    localparam logic [BANK_W:0] NB = (BANK_W+1)'(NUM_BANKS);

    AST_RDV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(op_valid && !restore_req && !op_sel[0])); // R2

    AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !restore_req && op_sel == 2'b01 && full_sel && priv_mode)
        |=> (cpsr_q == $past(src_value)) && mode_chg); // R3

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !restore_req && op_sel == 2'b01 && !full_sel)
        |=> cpsr_q == (($past(cpsr_q) & ~FMASK) | ($past(src_value) & FMASK))); // R4

    AST_UNPRIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !restore_req && op_sel == 2'b01 && !priv_mode)
        |=> (cpsr_q[DATA_W-FLAG_W-1:0] == $past(cpsr_q[DATA_W-FLAG_W-1:0])) && !mode_chg); // R5

    AST_SAV_NO_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !restore_req && op_sel[1]) |=> $stable(cpsr_q)); // R7

    AST_UNPRIV_SAV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !restore_req && op_sel == 2'b10 && !priv_mode)
        |=> !rd_valid && $stable(rd_data)); // R8

    AST_BAD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !restore_req && op_sel == 2'b10 && ({1'b0, bank_idx} >= NB))
        |=> !rd_valid); // R8

    AST_MCHG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> $past(priv_mode && (restore_req || (op_valid && op_sel == 2'b01 && full_sel)))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !restore_req) |=> $stable(cpsr_q) && !rd_valid && !mode_chg); // R11
endmodule

bind psr_xfer_unit psr_xfer_checker #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .full_sel(full_sel), .src_value(src_value), .priv_mode(priv_mode),
    .bank_idx(bank_idx), .restore_req(restore_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .cpsr_q(cpsr_q), .mode_chg(mode_chg)
);

// File: tb/psr_xfer_unit_bench.sv
// Bench: walks a vector table of one-edge operations and then runs directed
// reset checks; expected values come from the requirements.
module psr_xfer_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    typedef struct packed {
        logic        vld;
        logic [1:0]  op;
        logic        full;
        logic        priv;
        logic [2:0]  bank;
        logic        rst_rq;
        logic [31:0] src;
        logic [31:0] e_cpsr;
        logic        e_rv;
        logic [31:0] e_rd;
        logic        e_mc;
        logic [7:0]  req;
    } vec_t;

    // Fields: vld op full priv bank restore src | cpsr rv rd mc | req
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,2'd0,1'b0,1'b1,3'd0,1'b0,32'h0,          32'h0000_00D3,1'b1,32'h0000_00D3,1'b0,8'd2},  // R2
        '{1'b1,2'd1,1'b1,1'b1,3'd0,1'b0,32'h6000_001F,  32'h6000_001F,1'b0,32'h0000_00D3,1'b1,8'd3},  // R3
        '{1'b1,2'd1,1'b0,1'b1,3'd0,1'b0,32'hA123_4567,  32'hA000_001F,1'b0,32'h0000_00D3,1'b0,8'd4},  // R4
        '{1'b1,2'd1,1'b1,1'b0,3'd0,1'b0,32'h5000_0010,  32'h5000_001F,1'b0,32'h0000_00D3,1'b0,8'd5},  // R5
        '{1'b1,2'd3,1'b1,1'b1,3'd1,1'b0,32'h1234_5678,  32'h5000_001F,1'b0,32'h0000_00D3,1'b0,8'd7},  // R7
        '{1'b1,2'd3,1'b0,1'b1,3'd1,1'b0,32'hF000_0000,  32'h5000_001F,1'b0,32'h0000_00D3,1'b0,8'd7},  // R7
        '{1'b1,2'd2,1'b0,1'b1,3'd1,1'b0,32'h0,          32'h5000_001F,1'b1,32'hF234_5678,1'b0,8'd6},  // R6
        '{1'b1,2'd3,1'b1,1'b1,3'd2,1'b0,32'h0000_0011,  32'h5000_001F,1'b0,32'hF234_5678,1'b0,8'd7},  // R7
        '{1'b1,2'd2,1'b0,1'b1,3'd1,1'b0,32'h0,          32'h5000_001F,1'b1,32'hF234_5678,1'b0,8'd10}, // R10
        '{1'b1,2'd2,1'b0,1'b1,3'd2,1'b0,32'h0,          32'h5000_001F,1'b1,32'h0000_0011,1'b0,8'd6},  // R6
        '{1'b1,2'd3,1'b1,1'b0,3'd1,1'b0,32'hDEAD_BEEF,  32'h5000_001F,1'b0,32'h0000_0011,1'b0,8'd8},  // R8
        '{1'b1,2'd2,1'b0,1'b0,3'd1,1'b0,32'h0,          32'h5000_001F,1'b0,32'h0000_0011,1'b0,8'd8},  // R8
        '{1'b1,2'd2,1'b0,1'b1,3'd1,1'b0,32'h0,          32'h5000_001F,1'b1,32'hF234_5678,1'b0,8'd8},  // R8
        '{1'b1,2'd3,1'b1,1'b1,3'd6,1'b0,32'h0,          32'h5000_001F,1'b0,32'hF234_5678,1'b0,8'd8},  // R8
        '{1'b1,2'd2,1'b0,1'b1,3'd6,1'b0,32'h0,          32'h5000_001F,1'b0,32'hF234_5678,1'b0,8'd8},  // R8
        '{1'b1,2'd1,1'b1,1'b1,3'd2,1'b1,32'hFFFF_FFFF,  32'h0000_0011,1'b0,32'hF234_5678,1'b1,8'd9},  // R9
        '{1'b0,2'd1,1'b1,1'b1,3'd0,1'b0,32'h0,          32'h0000_0011,1'b0,32'hF234_5678,1'b0,8'd11}, // R11
        '{1'b0,2'd0,1'b0,1'b0,3'd1,1'b1,32'h0,          32'h0000_0011,1'b0,32'hF234_5678,1'b0,8'd9},  // R9
        '{1'b1,2'd2,1'b0,1'b1,3'd0,1'b0,32'h0,          32'h0000_0011,1'b1,32'h0000_0000,1'b0,8'd1},  // R1
        '{1'b1,2'd0,1'b0,1'b1,3'd0,1'b0,32'h0,          32'h0000_0011,1'b1,32'h0000_0011,1'b0,8'd2}   // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic        full_sel = 1'b0;
    logic [31:0] src_value = '0;
    logic        priv_mode = 1'b0;
    logic [2:0]  bank_idx = '0;
    logic        restore_req = 1'b0;
    logic [31:0] rd_data, cpsr_q;
    logic        rd_valid, mode_chg;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_xfer_unit u_psr_xfer_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .full_sel(full_sel), .src_value(src_value), .priv_mode(priv_mode),
        .bank_idx(bank_idx), .restore_req(restore_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .cpsr_q(cpsr_q), .mode_chg(mode_chg)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        op_valid = 1'b0; restore_req = 1'b0; op_sel = '0; full_sel = 1'b0;
        src_value = '0; priv_mode = 1'b1; bank_idx = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(1, "reset cpsr", cpsr_q, 32'h0000_00D3);
        check(1, "reset rd_valid", {31'b0, rd_valid}, 32'h0);
        check(1, "reset mode_chg", {31'b0, mode_chg}, 32'h0);
        check(1, "reset rd_data", rd_data, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            op_valid = VECS[i].vld; op_sel = VECS[i].op; full_sel = VECS[i].full;
            priv_mode = VECS[i].priv; bank_idx = VECS[i].bank;
            restore_req = VECS[i].rst_rq; src_value = VECS[i].src;
            @(posedge clk);
            @(negedge clk);
            check(int'(VECS[i].req), $sformatf("vec%0d cpsr", i), cpsr_q, VECS[i].e_cpsr);
            check(int'(VECS[i].req), $sformatf("vec%0d rd_valid", i), {31'b0, rd_valid}, {31'b0, VECS[i].e_rv});
            check(int'(VECS[i].req), $sformatf("vec%0d rd_data", i), rd_data, VECS[i].e_rd);
            check(int'(VECS[i].req), $sformatf("vec%0d mode_chg", i), {31'b0, mode_chg}, {31'b0, VECS[i].e_mc});
        end

        // R3: mode_chg lasts one cycle only
        drive_idle();
        op_valid = 1'b1; op_sel = 2'd1; full_sel = 1'b1; src_value = 32'h0000_0012;
        @(posedge clk); @(negedge clk);
        check(3, "strobe high", {31'b0, mode_chg}, 32'h1);
        drive_idle();
        @(posedge clk); @(negedge clk);
        check(3, "strobe drops", {31'b0, mode_chg}, 32'h0);

        // R1: mid-run reset restores the current word and clears saved words
        drive_idle();
        op_valid = 1'b1; op_sel = 2'd3; full_sel = 1'b1; bank_idx = 3'd4; src_value = 32'hCAFE_0001;
        @(posedge clk); @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        check(1, "re-reset cpsr", cpsr_q, 32'h0000_00D3);
        op_valid = 1'b1; op_sel = 2'd2; bank_idx = 3'd4;
        @(posedge clk); @(negedge clk);
        check(1, "re-reset saved word", rd_data, 32'h0);
        check(1, "re-reset read valid", {31'b0, rd_valid}, 32'h1);

        // R10: bank 4 written, bank 3 untouched
        drive_idle();
        op_valid = 1'b1; op_sel = 2'd3; full_sel = 1'b1; bank_idx = 3'd4; src_value = 32'h0BAD_F00D;
        @(posedge clk); @(negedge clk);
        op_sel = 2'd2; bank_idx = 3'd3;
        @(posedge clk); @(negedge clk);
        check(10, "neighbour bank", rd_data, 32'h0);
        bank_idx = 3'd4;
        @(posedge clk); @(negedge clk);
        check(6, "top bank read", rd_data, 32'h0BAD_F00D);

        drive_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule